// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Register

This unit carries out the data operations of a classic 8-bit accumulator processor and owns that processor's status register. Each cycle in which `op_valid` is high, it takes an operation code, the accumulator value, the X index value and an operand byte. It then produces a result byte together with a code that says where the result belongs: nowhere, the accumulator, X or memory. On the same clock edge it updates the status register it holds.

The supported work covers several groups:
- binary add and subtract with carry;
- AND, OR and XOR;
- compares against A or X;
- a bit test;
- shifts and rotates on A or on a memory byte;
- memory increment and decrement;
- single-flag set and clear;
- loading the status register from a popped byte, and producing the image that is pushed.

Four undocumented combined operations are also included. The decimal flag is kept but never changes the arithmetic. All outputs are registered, so an operation issued in one cycle is visible after the next rising edge. An operation that follows directly sees the carry and other flags left by the operation before it.

Top module: `byte_alu_core`

## Requirements
- R1: While `rst` is high at a rising edge, `status` becomes 0x24 (interrupt-disable and bit 5 set), `result` 0x00, `dest` 0 and `res_valid` 0.
- R2: Add (code 1) forms A + operand + carry. Subtract (code 2) forms A + ~operand + carry. In both, carry (bit 0) is bit 8 of the sum and overflow (bit 6) is set when both addends share a sign that the result lacks. The result goes to A (dest 1), and the decimal flag (bit 3) has no effect.
- R3: Compare A (code 6) or X (code 7) with the operand sets carry when the register is at least the operand, zero (bit 1) when they are equal, and negative (bit 7) from bit 7 of the 8-bit difference. Dest is 0.
- R4: Shift left, shift right, rotate left and rotate right act on A (codes 10 to 13, dest 1) or on the operand (codes 14 to 17, dest 3). The outgoing bit goes to carry, and the vacated bit takes the old carry for rotates and zero for shifts.
- R5: AND, OR, XOR and load (codes 3, 4, 5, 9) write to A, and increment and decrement of the operand (codes 18, 19) write to memory. Zero and negative follow the result. Whenever dest is 1 or 2, zero and negative match the result byte.
- R6: Bit test (code 8) sets zero when A AND operand is 0, copies operand bit 6 to overflow and operand bit 7 to negative, and leaves carry, interrupt-disable and decimal unchanged. Dest is 0.
- R7: Codes 20 to 26 clear carry, set carry, clear interrupt-disable, set it, clear decimal, set it, and clear overflow. Each changes only its own flag.
- R8: Status load (code 27) stores the operand with bit 4 cleared and bit 5 set. Status push (code 28) returns the status with bits 4 and 5 set as a memory result (dest 3) and leaves the status unchanged.
- R9: AND-rotate-right (code 29) writes {old carry, (A AND operand) >> 1} to A. Carry becomes result bit 6, overflow becomes result bit 6 XOR bit 5, and zero and negative follow the result.
- R10: AND-X-subtract (code 30) writes (A AND X) - operand to X (dest 2). Carry is set when (A AND X) is at least the operand, and zero and negative follow the new X.
- R11: AND-shift-right (code 31) writes (A AND operand) >> 1 to A, with bit 0 of the AND going to carry. AND-copy-sign (code 32) writes A AND operand to A, and both carry and negative take its bit 7.
- R12: With `op_valid` low, `res_valid` is 0 one edge later and the status is held. Code 0 and codes 33 to 63 give dest 0 and leave the status unchanged.
- R13: Status bit 5 always reads 1 and bit 4 always reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 6 | Operation code |
| acc_in | input | 8 | Accumulator value |
| xreg_in | input | 8 | X index register value |
| operand_in | input | 8 | Operand byte (immediate, memory or popped status) |
| res_valid | output | 1 | Registered outputs hold a new operation's result |
| result | output | 8 | Result byte |
| dest | output | 2 | Result destination: 0 none, 1 A, 2 X, 3 memory |
| status | output | 8 | Status register after the operation |

## Verification
The assertions assume that `rst` is high from time zero until the first edges have passed. They also assume that `op_valid`, `op_sel` and the data inputs carry defined values whenever reset is low. Their status checks rely on carry-in coming from the held register, not from the port data. The stimulus holds reset from the first instant and always drives every input with a concrete value. This includes the idle cycles and the unused operation codes, so no property samples an unknown.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int DATA_W = 8;
  localparam int OP_W   = 6;

  // status bit positions
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_I = 2;
  localparam int FL_D = 3;
  localparam int FL_B = 4;
  localparam int FL_U = 5;
  localparam int FL_V = 6;
  localparam int FL_N = 7;

  localparam logic [DATA_W-1:0] MSK_C  = DATA_W'(1) << FL_C;
  localparam logic [DATA_W-1:0] MSK_Z  = DATA_W'(1) << FL_Z;
  localparam logic [DATA_W-1:0] MSK_I  = DATA_W'(1) << FL_I;
  localparam logic [DATA_W-1:0] MSK_D  = DATA_W'(1) << FL_D;
  localparam logic [DATA_W-1:0] MSK_B  = DATA_W'(1) << FL_B;
  localparam logic [DATA_W-1:0] MSK_U  = DATA_W'(1) << FL_U;
  localparam logic [DATA_W-1:0] MSK_V  = DATA_W'(1) << FL_V;
  localparam logic [DATA_W-1:0] MSK_N  = DATA_W'(1) << FL_N;
  localparam logic [DATA_W-1:0] MSK_ZN = MSK_Z | MSK_N;

  localparam logic [DATA_W-1:0] ST_RESET = MSK_I | MSK_U;

  // operation codes
  localparam logic [OP_W-1:0] OP_NOP  = 6'd0;
  localparam logic [OP_W-1:0] OP_ADC  = 6'd1;
  localparam logic [OP_W-1:0] OP_SBC  = 6'd2;
  localparam logic [OP_W-1:0] OP_AND  = 6'd3;
  localparam logic [OP_W-1:0] OP_OR   = 6'd4;
  localparam logic [OP_W-1:0] OP_XOR  = 6'd5;
  localparam logic [OP_W-1:0] OP_CMPA = 6'd6;
  localparam logic [OP_W-1:0] OP_CMPX = 6'd7;
  localparam logic [OP_W-1:0] OP_BIT  = 6'd8;
  localparam logic [OP_W-1:0] OP_LD   = 6'd9;
  localparam logic [OP_W-1:0] OP_SLA  = 6'd10;
  localparam logic [OP_W-1:0] OP_SRA  = 6'd11;
  localparam logic [OP_W-1:0] OP_RLA  = 6'd12;
  localparam logic [OP_W-1:0] OP_RRA  = 6'd13;
  localparam logic [OP_W-1:0] OP_SLM  = 6'd14;
  localparam logic [OP_W-1:0] OP_SRM  = 6'd15;
  localparam logic [OP_W-1:0] OP_RLM  = 6'd16;
  localparam logic [OP_W-1:0] OP_RRM  = 6'd17;
  localparam logic [OP_W-1:0] OP_INCM = 6'd18;
  localparam logic [OP_W-1:0] OP_DECM = 6'd19;
  localparam logic [OP_W-1:0] OP_CLRC = 6'd20;
  localparam logic [OP_W-1:0] OP_SETC = 6'd21;
  localparam logic [OP_W-1:0] OP_CLRI = 6'd22;
  localparam logic [OP_W-1:0] OP_SETI = 6'd23;
  localparam logic [OP_W-1:0] OP_CLRD = 6'd24;
  localparam logic [OP_W-1:0] OP_SETD = 6'd25;
  localparam logic [OP_W-1:0] OP_CLRV = 6'd26;
  localparam logic [OP_W-1:0] OP_STLD = 6'd27;
  localparam logic [OP_W-1:0] OP_STPU = 6'd28;
  localparam logic [OP_W-1:0] OP_ANDR = 6'd29;
  localparam logic [OP_W-1:0] OP_XSUB = 6'd30;
  localparam logic [OP_W-1:0] OP_ANDS = 6'd31;
  localparam logic [OP_W-1:0] OP_ANDN = 6'd32;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_A    = 2'd1,
    DST_X    = 2'd2,
    DST_MEM  = 2'd3
  } dest_e;

endpackage

// File: rtl/byte_alu_adder.sv
module byte_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;

  assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  // same-sign addends whose sum flips sign
  assign ovf  = (a[W-1] ~^ b[W-1]) & (sum[W-1] ^ a[W-1]);
endmodule

// File: rtl/byte_alu_shifter.sv
module byte_alu_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  input  logic         cin,
  input  logic         right,
  input  logic         rotate,
  output logic [W-1:0] out,
  output logic         cout
);
  logic fill;

  assign fill = rotate & cin;
  assign out  = right ? {fill, val[W-1:1]} : {val[W-2:0], fill};
  assign cout = right ? val[0] : val[W-1];
endmodule

// File: rtl/byte_alu_status.sv
module byte_alu_status
  import byte_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] nxt,
  output logic [DATA_W-1:0] status
);
  logic [DATA_W-1:0] st_q;
  logic [DATA_W-1:0] merged;

  assign merged = (st_q & ~mask) | (nxt & mask);

  always_ff @(posedge clk) begin
    if (rst)      st_q <= ST_RESET;
    else if (upd) st_q <= (merged & ~MSK_B) | MSK_U;
  end

  assign status = st_q;

  // R12: no update request keeps every bit
  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(status));

  // R7: bits outside the mask are untouched by an update
  assert_masked_R7: assert property (@(posedge clk) disable iff (rst)
    upd |=> ((status & ~$past(mask)) == ($past(status) & ~$past(mask) & ~MSK_B | (MSK_U & ~$past(mask)))));
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
  import byte_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] xreg_in,
  input  logic [DATA_W-1:0] operand_in,
  output logic              res_valid,
  output logic [DATA_W-1:0] result,
  output logic [1:0]        dest,
  output logic [DATA_W-1:0] status
);
  localparam int MSB = DATA_W - 1;

  // adder for add / subtract
  logic [DATA_W-1:0] add_b, add_sum;
  logic              add_c, add_v;
  // adder for compare / AND-X-subtract
  logic [DATA_W-1:0] cmp_a, cmp_sum;
  logic              cmp_c, cmp_v;
  // shifter
  logic [DATA_W-1:0] sh_in, sh_out;
  logic              sh_right, sh_rot, sh_c;

  logic [DATA_W-1:0] and_am, and_ax, arr_v;
  logic              c_old;

  logic [DATA_W-1:0] res_n, fmask, fnew;
  dest_e             dst_n;
  logic              zn_en;

  logic [DATA_W-1:0] res_q;
  dest_e             dst_q;
  logic              vld_q;

  assign c_old  = status[FL_C];
  assign and_am = acc_in & operand_in;
  assign and_ax = acc_in & xreg_in;
  assign arr_v  = {c_old, and_am[MSB:1]};

  assign add_b = (op_sel == OP_SBC) ? ~operand_in : operand_in;

  byte_alu_adder #(.W(DATA_W)) u_add (
    .a(acc_in), .b(add_b), .cin(c_old),
    .sum(add_sum), .cout(add_c), .ovf(add_v)
  );

  always_comb begin
    unique case (op_sel)
      OP_CMPX: cmp_a = xreg_in;
      OP_XSUB: cmp_a = and_ax;
      default: cmp_a = acc_in;
    endcase
  end

  byte_alu_adder #(.W(DATA_W)) u_cmp (
    .a(cmp_a), .b(~operand_in), .cin(1'b1),
    .sum(cmp_sum), .cout(cmp_c), .ovf(cmp_v)
  );

  always_comb begin
    sh_in    = acc_in;
    sh_right = 1'b0;
    sh_rot   = 1'b0;
    unique case (op_sel)
      OP_SLM, OP_SRM, OP_RLM, OP_RRM: sh_in = operand_in;
      OP_ANDS: sh_in = and_am;
      default: sh_in = acc_in;
    endcase
    if (op_sel == OP_SRA || op_sel == OP_SRM || op_sel == OP_RRA ||
        op_sel == OP_RRM || op_sel == OP_ANDS)
      sh_right = 1'b1;
    if (op_sel == OP_RLA || op_sel == OP_RLM || op_sel == OP_RRA ||
        op_sel == OP_RRM)
      sh_rot = 1'b1;
  end

  byte_alu_shifter #(.W(DATA_W)) u_sh (
    .val(sh_in), .cin(c_old), .right(sh_right), .rotate(sh_rot),
    .out(sh_out), .cout(sh_c)
  );

  // operation select and flag planning
  always_comb begin
    res_n = '0;
    dst_n = DST_NONE;
    fmask = '0;
    fnew  = '0;
    zn_en = 1'b0;
    case (op_sel)
      OP_ADC, OP_SBC: begin
        res_n = add_sum; dst_n = DST_A; zn_en = 1'b1;
        fmask = MSK_C | MSK_V;
        fnew[FL_C] = add_c; fnew[FL_V] = add_v;
      end
      OP_AND: begin res_n = and_am;                  dst_n = DST_A; zn_en = 1'b1; end
      OP_OR:  begin res_n = acc_in | operand_in;     dst_n = DST_A; zn_en = 1'b1; end
      OP_XOR: begin res_n = acc_in ^ operand_in;     dst_n = DST_A; zn_en = 1'b1; end
      OP_LD:  begin res_n = operand_in;              dst_n = DST_A; zn_en = 1'b1; end
      OP_CMPA, OP_CMPX: begin
        res_n = cmp_sum; zn_en = 1'b1;
        fmask = MSK_C; fnew[FL_C] = cmp_c;
      end
      OP_BIT: begin
        res_n = and_am;
        fmask = MSK_Z | MSK_V | MSK_N;
        fnew[FL_Z] = (and_am == '0);
        fnew[FL_V] = operand_in[FL_V];
        fnew[FL_N] = operand_in[FL_N];
      end
      OP_SLA, OP_SRA, OP_RLA, OP_RRA: begin
        res_n = sh_out; dst_n = DST_A; zn_en = 1'b1;
        fmask = MSK_C; fnew[FL_C] = sh_c;
      end
      OP_SLM, OP_SRM, OP_RLM, OP_RRM: begin
        res_n = sh_out; dst_n = DST_MEM; zn_en = 1'b1;
        fmask = MSK_C; fnew[FL_C] = sh_c;
      end
      OP_INCM: begin res_n = operand_in + 1'b1; dst_n = DST_MEM; zn_en = 1'b1; end
      OP_DECM: begin res_n = operand_in - 1'b1; dst_n = DST_MEM; zn_en = 1'b1; end
      OP_CLRC: begin fmask = MSK_C; fnew[FL_C] = 1'b0; end
      OP_SETC: begin fmask = MSK_C; fnew[FL_C] = 1'b1; end
      OP_CLRI: begin fmask = MSK_I; fnew[FL_I] = 1'b0; end
      OP_SETI: begin fmask = MSK_I; fnew[FL_I] = 1'b1; end
      OP_CLRD: begin fmask = MSK_D; fnew[FL_D] = 1'b0; end
      OP_SETD: begin fmask = MSK_D; fnew[FL_D] = 1'b1; end
      OP_CLRV: begin fmask = MSK_V; fnew[FL_V] = 1'b0; end
      OP_STLD: begin
        res_n = operand_in;
        fmask = '1; fnew = operand_in;
      end
      OP_STPU: begin
        res_n = status | MSK_B | MSK_U; dst_n = DST_MEM;
      end
      OP_ANDR: begin
        res_n = arr_v; dst_n = DST_A; zn_en = 1'b1;
        fmask = MSK_C | MSK_V;
        fnew[FL_C] = arr_v[6];
        fnew[FL_V] = arr_v[6] ^ arr_v[5];
      end
      OP_XSUB: begin
        res_n = cmp_sum; dst_n = DST_X; zn_en = 1'b1;
        fmask = MSK_C; fnew[FL_C] = cmp_c;
      end
      OP_ANDS: begin
        res_n = sh_out; dst_n = DST_A; zn_en = 1'b1;
        fmask = MSK_C; fnew[FL_C] = sh_c;
      end
      OP_ANDN: begin
        res_n = and_am; dst_n = DST_A; zn_en = 1'b1;
        fmask = MSK_C; fnew[FL_C] = and_am[MSB];
      end
      default: begin
        res_n = '0;
      end
    endcase
    if (zn_en) begin
      fmask      = fmask | MSK_ZN;
      fnew[FL_Z] = (res_n == '0);
      fnew[FL_N] = res_n[MSB];
    end
  end

  byte_alu_status u_st (
    .clk(clk), .rst(rst), .upd(op_valid),
    .mask(fmask), .nxt(fnew), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      dst_q <= DST_NONE;
      vld_q <= 1'b0;
    end else begin
      vld_q <= op_valid;
      if (op_valid) begin
        res_q <= res_n;
        dst_q <= dst_n;
      end
    end
  end

  assign result    = res_q;
  assign dest      = dst_q;
  assign res_valid = vld_q;

  // R12: valid follows the request by one edge
  assert_valid_follow_R12: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  // R5: register writes always leave zero/negative matching the byte
  assert_zn_match_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (dest == DST_A || dest == DST_X)) |->
      (status[FL_Z] == (result == '0)) && (status[FL_N] == result[MSB]));

  // R8: pushed image has break and bit 5 set
  assert_push_image_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_STPU) |=> result[FL_B] && result[FL_U] && (dest == DST_MEM));

  // R9: AND-rotate flags derived from the written byte
  assert_andr_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_ANDR) |=>
      (status[FL_C] == result[6]) && (status[FL_V] == (result[6] ^ result[5])));

  // R2: subtracting an equal value with carry set gives zero with carry
  assert_sbc_equal_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_SBC && acc_in == operand_in && status[FL_C]) |=>
      status[FL_C] && status[FL_Z]);

  // R3: compares and bit test never name a destination
  assert_cmp_dest_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == OP_CMPA || op_sel == OP_CMPX || op_sel == OP_BIT)) |=>
      dest == DST_NONE);

  // R13: fixed status bits
  assert_fixed_bits_R13: assert property (@(posedge clk) disable iff (rst)
    $past(op_valid) |-> status[FL_U] && !status[FL_B]);
endmodule

// File: tb/byte_alu_core_tb.sv
module byte_alu_core_tb;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [5:0] op_sel = 6'd0;
  logic [7:0] acc_in = 8'h00, xreg_in = 8'h00, operand_in = 8'h00;
  logic       res_valid;
  logic [7:0] result;
  logic [1:0] dest;
  logic [7:0] status;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [7:0] exp_st = 8'h24;

  always #(CLK_NS/2) clk = ~clk;

  byte_alu_core u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .xreg_in(xreg_in), .operand_in(operand_in),
    .res_valid(res_valid), .result(result), .dest(dest), .status(status)
  );

  function automatic string req_tag(input logic [5:0] op);
    if (op == 1 || op == 2)               return "R2";
    if (op == 6 || op == 7)               return "R3";
    if (op == 8)                          return "R6";
    if (op >= 10 && op <= 17)             return "R4";
    if (op inside {3, 4, 5, 9, 18, 19})   return "R5";
    if (op >= 20 && op <= 26)             return "R7";
    if (op == 27 || op == 28)             return "R8";
    if (op == 29)                         return "R9";
    if (op == 30)                         return "R10";
    if (op == 31 || op == 32)             return "R11";
    return "R12";
  endfunction

  // reference: {dest, result, status}
  function automatic logic [17:0] ref_op(input logic [5:0] op,
      input logic [7:0] a, input logic [7:0] x, input logic [7:0] m,
      input logic [7:0] st);
    logic [7:0] r, s, b, t;
    logic [8:0] w;
    logic [1:0] d;
    bit zn;
    s = st; r = 8'h00; d = 2'd0; zn = 0;
    case (op)
      1, 2: begin
        b = (op == 2) ? ~m : m;
        w = {1'b0, a} + {1'b0, b} + {8'h00, st[0]};
        r = w[7:0]; s[0] = w[8];
        s[6] = (a[7] == b[7]) && (r[7] != a[7]);
        d = 1; zn = 1;
      end
      3: begin r = a & m; d = 1; zn = 1; end
      4: begin r = a | m; d = 1; zn = 1; end
      5: begin r = a ^ m; d = 1; zn = 1; end
      6: begin r = a - m; s[0] = (a >= m); zn = 1; end
      7: begin r = x - m; s[0] = (x >= m); zn = 1; end
      8: begin s[1] = ((a & m) == 0); s[6] = m[6]; s[7] = m[7]; end
      9: begin r = m; d = 1; zn = 1; end
      10: begin r = a << 1; s[0] = a[7]; d = 1; zn = 1; end
      11: begin r = a >> 1; s[0] = a[0]; d = 1; zn = 1; end
      12: begin r = {a[6:0], st[0]}; s[0] = a[7]; d = 1; zn = 1; end
      13: begin r = {st[0], a[7:1]}; s[0] = a[0]; d = 1; zn = 1; end
      14: begin r = m << 1; s[0] = m[7]; d = 3; zn = 1; end
      15: begin r = m >> 1; s[0] = m[0]; d = 3; zn = 1; end
      16: begin r = {m[6:0], st[0]}; s[0] = m[7]; d = 3; zn = 1; end
      17: begin r = {st[0], m[7:1]}; s[0] = m[0]; d = 3; zn = 1; end
      18: begin r = m + 8'd1; d = 3; zn = 1; end
      19: begin r = m - 8'd1; d = 3; zn = 1; end
      20: s[0] = 1'b0;
      21: s[0] = 1'b1;
      22: s[2] = 1'b0;
      23: s[2] = 1'b1;
      24: s[3] = 1'b0;
      25: s[3] = 1'b1;
      26: s[6] = 1'b0;
      27: s = (m & 8'hCF) | 8'h20;
      28: begin r = st | 8'h30; d = 3; end
      29: begin
        t = a & m; r = {st[0], t[7:1]};
        s[0] = r[6]; s[6] = r[6] ^ r[5]; d = 1; zn = 1;
      end
      30: begin t = a & x; r = t - m; s[0] = (t >= m); d = 2; zn = 1; end
      31: begin t = a & m; s[0] = t[0]; r = t >> 1; d = 1; zn = 1; end
      32: begin r = a & m; s[0] = r[7]; d = 1; zn = 1; end
      default: ;
    endcase
    if (zn) begin s[1] = (r == 8'h00); s[7] = r[7]; end
    return {d, r, s};
  endfunction

  task automatic check8(input string tag, input string what,
                        input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
    end
  endtask

  // caller is at a falling edge; returns at the next falling edge
  task automatic run_op(input logic [5:0] op, input logic [7:0] a,
                        input logic [7:0] x, input logic [7:0] m);
    logic [17:0] e;
    string tag;
    e = ref_op(op, a, x, m, exp_st);
    tag = req_tag(op);
    op_valid = 1'b1; op_sel = op; acc_in = a; xreg_in = x; operand_in = m;
    @(negedge clk);
    exp_st = e[7:0];
    check8(tag, "valid", {7'd0, res_valid}, 8'h01);
    check8(tag, "dest", {6'd0, dest}, {6'd0, e[17:16]});
    check8(tag, "status", status, e[7:0]);
    if (e[17:16] != 2'd0) check8(tag, "result", result, e[15:8]);
  endtask

  task automatic idle_cycle();
    op_valid = 1'b0; op_sel = 6'd1; acc_in = 8'hFF; operand_in = 8'hFF;
    @(negedge clk);
    check8("R12", "idle valid", {7'd0, res_valid}, 8'h00);
    check8("R12", "idle status", status, exp_st);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    check8("R1", "reset status", status, 8'h24);
    check8("R1", "reset result", result, 8'h00);
    check8("R1", "reset dest", {6'd0, dest}, 8'h00);
    check8("R1", "reset valid", {7'd0, res_valid}, 8'h00);

    // R7 carry clear then R2 signed overflow
    run_op(6'd20, 8'h00, 8'h00, 8'h00);
    run_op(6'd1, 8'h7F, 8'h00, 8'h01);
    check8("R2", "7F+01 result", result, 8'h80);
    check8("R2", "7F+01 status", status, 8'hE4);
    run_op(6'd1, 8'hFF, 8'h00, 8'h01);
    check8("R2", "FF+01 carry/zero", status & 8'h03, 8'h03);
    // R2 subtract with decimal set has no effect on arithmetic
    run_op(6'd25, 8'h00, 8'h00, 8'h00);
    run_op(6'd21, 8'h00, 8'h00, 8'h00);
    run_op(6'd2, 8'h15, 8'h00, 8'h06);
    check8("R2", "decimal ignored", result, 8'h0F);
    // R3 equal compare
    run_op(6'd7, 8'h00, 8'h40, 8'h40);
    check8("R3", "equal flags", status & 8'h83, 8'h03);
    // R8 status load masking and push image
    run_op(6'd27, 8'h00, 8'h00, 8'hFF);
    check8("R8", "load FF", status, 8'hEF);
    run_op(6'd27, 8'h00, 8'h00, 8'h10);
    check8("R8", "load 10", status, 8'h20);
    run_op(6'd28, 8'h00, 8'h00, 8'h00);
    check8("R8", "push image", result, 8'h30);
    // R9 AND-rotate with carry in
    run_op(6'd21, 8'h00, 8'h00, 8'h00);
    run_op(6'd29, 8'hFF, 8'h00, 8'hC0);
    check8("R9", "andr result", result, 8'hE0);
    // R10 borrow case
    run_op(6'd30, 8'h0F, 8'h03, 8'h05);
    check8("R10", "xsub result", result, 8'hFE);
    // R11 shift case
    run_op(6'd31, 8'h03, 8'h00, 8'hFF);
    run_op(6'd32, 8'h80, 8'h00, 8'hFF);
    // R6 bit test, R12 unused code
    run_op(6'd8, 8'h01, 8'h00, 8'hC0);
    run_op(6'd50, 8'h12, 8'h34, 8'h56);
    run_op(6'd0, 8'h00, 8'h00, 8'h00);
    idle_cycle();

    for (int i = 0; i < 9000; i++) begin
      logic [5:0] op;
      op = 6'($urandom_range(0, 36));
      run_op(op, 8'($urandom), 8'($urandom), 8'($urandom));
      if ((i % 1000) == 999) idle_cycle();
    end
    // R13 after the random run
    op_valid = 1'b0;
    check8("R13", "fixed bits", status & 8'h30, 8'h20);
    done = 1'b1;
    finish_run();
  end
endmodule